// File: doc/BRIEF.md
# Majority-Voting Asynchronous Serial Receiver

This block receives non-return-to-zero serial characters from an already synchronised input line. Each character is one low start bit, then eight or nine data bits with the least significant bit first, then one high stop bit. A programmable divider makes an oversampling tick at sixteen times the bit rate. Each bit is split into sixteen tick phases. The receiver takes seven samples of the start and stop bits and three samples of each data bit, and a majority vote decides each bit. A single bad sample therefore does not corrupt the character, but it does raise a noise flag.

Bit timing is realigned whenever the line falls while a frame is in progress, so a sender whose rate differs from the local rate by several percent is still received correctly. The received character is held in one holding register. A full flag marks a character waiting to be read, and an acknowledge strobe clears it. A character that completes while the full flag is set is dropped, and an overrun flag is raised instead.

A standby request puts the receiver to sleep, so that it ignores traffic meant for other nodes. The receiver wakes by itself once the line has stayed high for one whole character time, which is in time for the first character of the next message.

Top module: `uart_rx_vote`

## Requirements
- R1: With `nine_bit_i` low, a frame made of a low start bit, 8 data bits sent LSB first and a high stop bit loads the data into `rx_data_o[7:0]`, clears `rx_data_o[8]` and sets `rx_full_o`. The load happens at the seventh stop-bit sample (phase 9).
- R2: With `nine_bit_i` high, 9 data bits are received LSB first into `rx_data_o[8:0]`.
- R3: Each data bit is sampled at tick phases 7, 8 and 9, and at least 2 of the 3 samples decide its value. One disagreeing sample leaves the data correct and sets `noise_o` for that character.
- R4: The start and stop bits are each sampled at phases 3 to 9, and at least 4 of the 7 samples decide their value. One disagreeing sample in either bit leaves the character correct and sets `noise_o`.
- R5: A stop bit whose majority is low sets `frame_err_o`, and the data is still delivered.
- R6: A low level that starts a frame but gives a start-bit majority of high is treated as a false start. No character is produced and the receiver goes back to hunting for a start bit.
- R7: A falling edge seen in a start or data bit at phase 12 or later ends that bit early. A falling edge seen at phases 1 to 2 of a start bit, or at phases 1 to 6 of a data bit, restarts the phase count. With this, frames whose bits last 15 or 17 ticks are received correctly.
- R8: If a character completes while `rx_full_o` is set, `overrun_o` is set and `rx_data_o` keeps the earlier character. A one-cycle `rd_ack_i` clears both `rx_full_o` and `overrun_o`.
- R9: A one-cycle `standby_req_i` sets `standby_o`. While `standby_o` is set, completed characters do not change `rx_data_o`, `rx_full_o` or any flag.
- R10: `standby_o` clears by itself after the line has been sampled high on 160 consecutive ticks (176 with `nine_bit_i` high). The next character is then received normally.
- R11: The oversampling tick occurs once every `baud_div_i`+1 clock cycles, so a bit lasts 16×(`baud_div_i`+1) clocks.
- R12: During reset all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_div_i | input | DIV_W | Tick divider; one tick every value+1 clocks |
| rx_i | input | 1 | Synchronised serial line |
| nine_bit_i | input | 1 | 1 = nine data bits, 0 = eight |
| standby_req_i | input | 1 | One-cycle pulse that enters standby |
| rd_ack_i | input | 1 | One-cycle pulse that clears full and overrun |
| rx_data_o | output | 9 | Received character |
| rx_full_o | output | 1 | Character waiting to be read |
| noise_o | output | 1 | A vote in the last character was not unanimous |
| frame_err_o | output | 1 | Stop bit of the last character was low |
| overrun_o | output | 1 | A character was lost while full was set |
| standby_o | output | 1 | Receiver is in standby |

## Verification
A wrong phase count or a bad resynchronisation step moves the sample points. This shows up within one character as a wrong data bit, a spurious noise flag or a false framing error. It is most visible on the frames with 15- and 17-tick bits and on the frames with one injected one-clock glitch. A vote accumulator that is not cleared at a bit boundary, or that adds a sample twice, corrupts the very next vote. A fault in the standby counter shows up as `standby_o` falling too early or too late around the 160-tick idle limit, or as a character leaking into the holding register while the receiver sleeps.

// File: rtl/uart_rx_vote_pkg.sv
package uart_rx_vote_pkg;
  localparam int OSR      = 16;
  localparam int PH_W     = $clog2(OSR);
  localparam int MAX_BITS = 9;
  localparam int BIT_W    = $clog2(MAX_BITS + 1);

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_STOP
  } rx_state_e;
endpackage

// File: rtl/rx_tick_div.sv
module rx_tick_div #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] baud_div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q, cnt_d;

  always_comb begin
    tick_o = (cnt_q >= baud_div_i);
    cnt_d  = tick_o ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R11
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && baud_div_i != '0) |=> (!tick_o || baud_div_i == '0));
endmodule

// File: rtl/rx_vote.sv
module rx_vote (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic smp_i,
  input  logic bit_i,
  input  logic wide_i,
  output logic maj_o,
  output logic noisy_o
);
  logic [2:0] ones_q, ones_d, tot_q, tot_d, ones_all, need;

  always_comb begin
    ones_all = ones_q + {2'b00, smp_i & bit_i};
    need     = wide_i ? 3'd7 : 3'd3;
    maj_o    = wide_i ? (ones_all >= 3'd4) : (ones_all >= 3'd2);
    noisy_o  = (ones_all != 3'd0) && (ones_all != need);
    ones_d   = ones_q;
    tot_d    = tot_q;
    if (clr_i) begin
      ones_d = '0;
      tot_d  = '0;
    end else if (smp_i) begin
      ones_d = ones_all;
      tot_d  = tot_q + 3'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ones_q <= '0;
      tot_q  <= '0;
    end else begin
      ones_q <= ones_d;
      tot_q  <= tot_d;
    end
  end

  // R3
  ones_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ones_q <= tot_q);
endmodule

// File: rtl/rx_standby.sv
module rx_standby #(
  parameter int OSR = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic rx_i,
  input  logic req_i,
  input  logic nine_i,
  output logic standby_o
);
  localparam int THR8  = 10 * OSR;
  localparam int THR9  = 11 * OSR;
  localparam int CNT_W = $clog2(THR9);

  logic [CNT_W-1:0] cnt_q, cnt_d, lim;
  logic             sb_q, sb_d;

  always_comb begin
    lim  = nine_i ? CNT_W'(THR9 - 1) : CNT_W'(THR8 - 1);
    cnt_d = cnt_q;
    sb_d  = sb_q;
    if (req_i) begin
      sb_d  = 1'b1;
      cnt_d = '0;
    end else if (sb_q && tick_i) begin
      if (!rx_i) begin
        cnt_d = '0;
      end else if (cnt_q >= lim) begin
        sb_d  = 1'b0;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sb_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      sb_q  <= sb_d;
    end
  end

  assign standby_o = sb_q;

  // R10
  wake_needs_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sb_q) |-> $past(rx_i));
endmodule

// File: rtl/uart_rx_vote.sv
module uart_rx_vote
  import uart_rx_vote_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] baud_div_i,
  input  logic             rx_i,
  input  logic             nine_bit_i,
  input  logic             standby_req_i,
  input  logic             rd_ack_i,
  output logic [8:0]       rx_data_o,
  output logic             rx_full_o,
  output logic             noise_o,
  output logic             frame_err_o,
  output logic             overrun_o,
  output logic             standby_o
);
  localparam logic [PH_W-1:0] SS_LO = PH_W'(3);
  localparam logic [PH_W-1:0] DS_LO = PH_W'(7);
  localparam logic [PH_W-1:0] DEC   = PH_W'(9);
  localparam logic [PH_W-1:0] EARLY = PH_W'(12);
  localparam logic [PH_W-1:0] PLAST = PH_W'(OSR - 1);
  localparam logic [PH_W-1:0] PONE  = PH_W'(1);

  logic tick, fall, v_clr, v_smp, v_wide, v_maj, v_noisy, done, stop_ok;
  logic bit_end;
  rx_state_e        st_q, st_d;
  logic [PH_W-1:0]  ph_q, ph_d;
  logic [BIT_W-1:0] bit_q, bit_d, last_bit;
  logic [8:0]       shf_q, shf_d, data_q, data_d;
  logic             nz_q, nz_d, prev_q;
  logic             full_q, full_d, ovr_q, ovr_d, fe_q, fe_d, nzo_q, nzo_d;

  rx_tick_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .baud_div_i(baud_div_i), .tick_o(tick));

  rx_vote u_vote (
    .clk(clk), .rst_n(rst_n), .clr_i(v_clr), .smp_i(v_smp), .bit_i(rx_i),
    .wide_i(v_wide), .maj_o(v_maj), .noisy_o(v_noisy));

  rx_standby #(.OSR(OSR)) u_sb (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .rx_i(rx_i),
    .req_i(standby_req_i), .nine_i(nine_bit_i), .standby_o(standby_o));

  // frame sequencer: next state
  always_comb begin
    st_d     = st_q;
    ph_d     = ph_q;
    bit_d    = bit_q;
    shf_d    = shf_q;
    nz_d     = nz_q;
    v_clr    = 1'b0;
    v_smp    = 1'b0;
    v_wide   = (st_q != ST_DATA);
    done     = 1'b0;
    stop_ok  = 1'b1;
    last_bit = nine_bit_i ? BIT_W'(8) : BIT_W'(7);
    fall     = tick && prev_q && !rx_i;
    bit_end  = (ph_q == PLAST) || (fall && ph_q >= EARLY);
    if (tick) begin
      ph_d = ph_q + 1'b1;
      unique case (st_q)
        ST_IDLE: begin
          ph_d = '0;
          if (!rx_i) begin
            st_d  = ST_START;
            ph_d  = PONE;
            v_clr = 1'b1;
            shf_d = '0;
            nz_d  = 1'b0;
          end
        end
        ST_START: begin
          v_smp = (ph_q >= SS_LO) && (ph_q <= DEC);
          if (fall && ph_q >= PONE && ph_q < SS_LO) ph_d = PONE;
          if (ph_q == DEC) begin
            if (v_maj) begin
              st_d = ST_IDLE;
              ph_d = '0;
            end else begin
              nz_d = nz_q | v_noisy;
            end
          end else if (bit_end) begin
            st_d  = ST_DATA;
            bit_d = '0;
            v_clr = 1'b1;
            ph_d  = fall ? PONE : '0;
          end
        end
        ST_DATA: begin
          v_smp = (ph_q >= DS_LO) && (ph_q <= DEC);
          if (fall && ph_q >= PONE && ph_q < DS_LO) ph_d = PONE;
          if (ph_q == DEC) begin
            shf_d[bit_q] = v_maj;
            nz_d         = nz_q | v_noisy;
          end else if (bit_end) begin
            v_clr = 1'b1;
            ph_d  = fall ? PONE : '0;
            if (bit_q >= last_bit) st_d = ST_STOP;
            else                   bit_d = bit_q + 1'b1;
          end
        end
        ST_STOP: begin
          v_smp = (ph_q >= SS_LO) && (ph_q <= DEC);
          if (ph_q == DEC) begin
            done    = 1'b1;
            stop_ok = v_maj;
            nz_d    = nz_q | v_noisy;
            st_d    = ST_IDLE;
            ph_d    = '0;
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  // holding register: next state
  always_comb begin
    full_d = full_q & ~rd_ack_i;
    ovr_d  = ovr_q & ~rd_ack_i;
    data_d = data_q;
    fe_d   = fe_q;
    nzo_d  = nzo_q;
    if (done && !standby_o) begin
      if (full_d) begin
        ovr_d = 1'b1;
      end else begin
        full_d = 1'b1;
        data_d = nine_bit_i ? shf_q : {1'b0, shf_q[7:0]};
        fe_d   = ~stop_ok;
        nzo_d  = nz_d;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      ph_q   <= '0;
      bit_q  <= '0;
      shf_q  <= '0;
      nz_q   <= 1'b0;
      prev_q <= 1'b1;
      full_q <= 1'b0;
      ovr_q  <= 1'b0;
      data_q <= '0;
      fe_q   <= 1'b0;
      nzo_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      ph_q   <= ph_d;
      bit_q  <= bit_d;
      shf_q  <= shf_d;
      nz_q   <= nz_d;
      if (tick) prev_q <= rx_i;
      full_q <= full_d;
      ovr_q  <= ovr_d;
      data_q <= data_d;
      fe_q   <= fe_d;
      nzo_q  <= nzo_d;
    end
  end

  assign rx_data_o   = data_q;
  assign rx_full_o   = full_q;
  assign noise_o     = nzo_q;
  assign frame_err_o = fe_q;
  assign overrun_o   = ovr_q;

  // R8
  overrun_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_o |-> rx_full_o);

  // R9
  standby_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (standby_o && $past(standby_o)) |-> ($stable(rx_data_o) && $stable(frame_err_o)));

  // R2
  bit_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DATA) |-> (bit_q <= BIT_W'(8)));

  // R1
  load_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_full_o) |-> ($past(st_q) == ST_STOP));
endmodule

// File: tb/tb_uart_rx_vote.sv
`timescale 1ns/1ps
module tb_uart_rx_vote;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] baud_div = 16'd0;
  logic        rx = 1'b1, nine = 1'b0, standby_req = 1'b0;
  logic        man_ack = 1'b0, mon_ack = 1'b0;
  logic        rd_ack;
  logic [8:0]  rx_data;
  logic        rx_full, noise, frame_err, overrun, standby;

  assign rd_ack = man_ack | mon_ack;

  typedef struct {
    logic [8:0] d;
    logic       fe;
    logic       nz;
    string      tag;
  } exp_t;

  exp_t  q[$];
  int    checks = 0, fails = 0;
  bit    auto_ack = 1'b1;
  string cur_tag = "R1";

  always #4 clk = ~clk;

  uart_rx_vote dut (
    .clk(clk), .rst_n(rst_n), .baud_div_i(baud_div), .rx_i(rx),
    .nine_bit_i(nine), .standby_req_i(standby_req), .rd_ack_i(rd_ack),
    .rx_data_o(rx_data), .rx_full_o(rx_full), .noise_o(noise),
    .frame_err_o(frame_err), .overrun_o(overrun), .standby_o(standby));

  task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic idle(int n);
    rx = 1'b1;
    repeat (n) @(negedge clk);
  endtask

  task automatic drive_bit(logic v, int len, int goff);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      rx = (i == goff) ? ~v : v;
    end
  endtask

  task automatic send(logic [8:0] d, int nb, logic stopv, int len, int gbit, int goff);
    for (int b = 0; b < nb + 2; b++) begin
      logic v;
      if (b == 0)           v = 1'b0;
      else if (b == nb + 1) v = stopv;
      else                  v = d[b-1];
      drive_bit(v, len, (b == gbit) ? goff : -1);
    end
    @(negedge clk);
    rx = 1'b1;
  endtask

  task automatic push(logic [8:0] d, logic fe, logic nz, string tag);
    exp_t e;
    e.d = d; e.fe = fe; e.nz = nz; e.tag = tag;
    q.push_back(e);
  endtask

  // monitor: pops expected items as characters arrive
  always @(negedge clk) begin
    if (mon_ack) begin
      mon_ack <= 1'b0;
    end else if (auto_ack && rst_n && rx_full) begin
      if (q.size() == 0) begin
        chk(1'b0, cur_tag, "unexpected character", 32'(rx_data), 32'h0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(rx_data == e.d, e.tag, "data", 32'(rx_data), 32'(e.d));
        chk(frame_err == e.fe, e.tag, "frame_err", 32'(frame_err), 32'(e.fe));
        chk(noise == e.nz, e.tag, "noise", 32'(noise), 32'(e.nz));
      end
      mon_ack <= 1'b1;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(rx_full == 1'b0 && overrun == 1'b0 && standby == 1'b0, "R12", "flags in reset",
        {rx_full, overrun, standby}, 0);
    chk(rx_data == 9'h0 && noise == 1'b0 && frame_err == 1'b0, "R12", "data in reset",
        32'(rx_data), 0);
    rst_n = 1'b1;
    idle(40);

    // R1 clean 8-bit characters
    cur_tag = "R1";
    push(9'h055, 0, 0, "R1"); send(9'h055, 8, 1, 16, -1, 0); idle(20);
    push(9'h0A3, 0, 0, "R1"); send(9'h0A3, 8, 1, 16, -1, 0); idle(20);
    push(9'h000, 0, 0, "R1"); send(9'h000, 8, 1, 16, -1, 0); idle(20);
    push(9'h0FF, 0, 0, "R1"); send(9'h1FF, 8, 1, 16, -1, 0); idle(20);

    // R2 nine data bits
    cur_tag = "R2"; nine = 1'b1; idle(20);
    push(9'h1A5, 0, 0, "R2"); send(9'h1A5, 9, 1, 16, -1, 0); idle(20);
    push(9'h0FF, 0, 0, "R2"); send(9'h0FF, 9, 1, 16, -1, 0); idle(20);
    nine = 1'b0; idle(20);

    // R3 one bad sample in a data bit
    cur_tag = "R3";
    push(9'h0A3, 0, 1, "R3"); send(9'h0A3, 8, 1, 16, 3, 8); idle(20);
    push(9'h0A3, 0, 1, "R3"); send(9'h0A3, 8, 1, 16, 1, 7); idle(20);

    // R4 one bad sample in start and in stop
    cur_tag = "R4";
    push(9'h05A, 0, 1, "R4"); send(9'h05A, 8, 1, 16, 0, 5); idle(20);
    push(9'h05A, 0, 1, "R4"); send(9'h05A, 8, 1, 16, 9, 6); idle(20);

    // R5 low stop bit
    cur_tag = "R5";
    push(9'h03C, 1, 0, "R5"); send(9'h03C, 8, 0, 16, -1, 0); idle(60);

    // R6 short low pulse, then a good character
    cur_tag = "R6";
    @(negedge clk); rx = 1'b0;
    repeat (3) @(negedge clk);
    idle(60);
    chk(rx_full == 1'b0, "R6", "false start full", 32'(rx_full), 0);
    chk(q.size() == 0, "R6", "pending after false start", q.size(), 0);
    push(9'h0C9, 0, 0, "R6"); send(9'h0C9, 8, 1, 16, -1, 0); idle(20);

    // R7 rate mismatch
    cur_tag = "R7";
    push(9'h055, 0, 0, "R7"); send(9'h055, 8, 1, 15, -1, 0); idle(20);
    push(9'h055, 0, 0, "R7"); send(9'h055, 8, 1, 17, -1, 0); idle(20);
    push(9'h033, 0, 0, "R7"); send(9'h033, 8, 1, 17, -1, 0); idle(20);

    // R11 divider of 2
    cur_tag = "R11"; baud_div = 16'd1; idle(20);
    push(9'h0C6, 0, 0, "R11"); send(9'h0C6, 8, 1, 32, -1, 0); idle(40);
    baud_div = 16'd0; idle(20);

    // R8 overrun
    cur_tag = "R8"; idle(10); auto_ack = 1'b0;
    send(9'h011, 8, 1, 16, -1, 0); idle(10);
    chk(rx_full == 1'b1 && overrun == 1'b0, "R8", "first char held", {rx_full, overrun}, 2);
    send(9'h022, 8, 1, 16, -1, 0); idle(10);
    chk(overrun == 1'b1, "R8", "overrun set", 32'(overrun), 1);
    chk(rx_data == 9'h011, "R8", "old data kept", 32'(rx_data), 32'h11);
    @(negedge clk); man_ack = 1'b1;
    @(negedge clk); man_ack = 1'b0;
    chk(rx_full == 1'b0 && overrun == 1'b0, "R8", "ack clears", {rx_full, overrun}, 0);
    auto_ack = 1'b1;

    // R9 standby ignores characters
    cur_tag = "R9";
    @(negedge clk); standby_req = 1'b1;
    @(negedge clk); standby_req = 1'b0;
    chk(standby == 1'b1, "R9", "standby entered", 32'(standby), 1);
    send(9'h055, 8, 1, 16, -1, 0);
    idle(100);
    chk(standby == 1'b1, "R9", "still asleep", 32'(standby), 1);
    chk(rx_full == 1'b0, "R9", "full untouched", 32'(rx_full), 0);
    chk(rx_data == 9'h011, "R9", "data untouched", 32'(rx_data), 32'h11);

    // R10 wake after a whole idle character
    cur_tag = "R10";
    idle(70);
    chk(standby == 1'b0, "R10", "woken by idle line", 32'(standby), 0);
    push(9'h096, 0, 0, "R10"); send(9'h096, 8, 1, 16, -1, 0); idle(30);

    chk(q.size() == 0, "R1", "characters still pending", q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule